// File: doc/BRIEF.md
# Per-Thread Load and Store Queue Tracker

This block keeps the in-flight memory operations of one thread of an out-of-order core in two ring buffers: one for loads and one for stores. Dispatch writes new entries at the tails. The commit port carries a youngest tag, and every entry at or older than that tag is committed. A load leaves its ring as soon as it commits. A committed store stays in its ring until a dedicated writeback pointer has sent it to the data cache, and its slot is reclaimed only after that.

The write port to the data cache sends at most one store per cycle, always the oldest committed store that has not been written yet. It holds back while the cache reports that it is blocked. A squash port removes every uncommitted entry younger than a given tag, so the core can recover from a misprediction. The block reports the occupancy of each ring, a merged free-slot count, full flags and the tags of the oldest entries. Tags are 16-bit values compared as unsigned numbers, and the tags inside the queue window never wrap.

Top module: `lsq_unit`

## Requirements
- R1: After reset both rings are empty: every count is 0, no full flag is set, wr_valid is 0, both head tags are 0, and free_slots equals the smaller of LQ_DEPTH-1 and SQ_DEPTH-1.
- R2: An accepted insert adds one to ld_count (or st_live) on the following clock edge. The head tag outputs show the oldest entry that is still held.
- R3: When cmt_valid is set, every load with tag <= cmt_seq is freed, and every uncommitted store with tag <= cmt_seq moves from st_live to st_wb. Both changes take effect at the next edge.
- R4: A ring reports full when its occupancy reaches depth-1. For stores, occupancy counts live, waiting and written-but-unfreed entries. lsq_full is the OR of the two full flags, and free_slots is the smaller of the two remaining counts.
- R5: An insert presented to a full ring is dropped, and the ring's occupancy does not change.
- R6: wr_valid is high in a cycle when the oldest committed unwritten store exists and dc_blocked is low. wr_seq, wr_size and wr_data then carry that store. Stores go out one per cycle in insertion order, and each write lowers st_wb by one at the next edge.
- R7: wr_valid is never high while dc_blocked is high, and a blocked store keeps its place.
- R8: A written store frees its slot one cycle after its write, so st_head_seq moves on to the next store at that point.
- R9: squash_valid removes every load and every uncommitted store whose tag is greater than squash_seq, and moves each tail back over the removed entries. Committed stores are kept.
- R10: In a cycle with squash_valid set, the inserts and the commit presented in that cycle are ignored.
- R11: ld_head_seq and st_head_seq read 0 whenever the matching ring holds no entry.
- R12: The ring pointers wrap correctly for any depth, including a store ring of 6 entries that is not a power of two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_ins_valid | input | 1 | Dispatch a load |
| ld_ins_seq | input | 16 | Tag of the dispatched load |
| st_ins_valid | input | 1 | Dispatch a store |
| st_ins_seq | input | 16 | Tag of the dispatched store |
| st_ins_size | input | 2 | Access size code of the store |
| st_ins_data | input | 32 | Store data word |
| cmt_valid | input | 1 | Commit request |
| cmt_seq | input | 16 | Youngest tag to commit |
| squash_valid | input | 1 | Squash request |
| squash_seq | input | 16 | Entries with a larger tag are removed |
| dc_blocked | input | 1 | Data cache cannot take a write |
| wr_valid | output | 1 | Store write to the cache this cycle |
| wr_seq | output | 16 | Tag of the written store |
| wr_size | output | 2 | Size code of the written store |
| wr_data | output | 32 | Data of the written store |
| ld_count | output | CW | Loads held |
| st_live | output | CW | Uncommitted stores held |
| st_wb | output | CW | Committed stores waiting for write |
| free_slots | output | CW | Smaller of the two free counts |
| lq_full | output | 1 | Load ring full |
| sq_full | output | 1 | Store ring full |
| lsq_full | output | 1 | Either ring full |
| ld_head_seq | output | 16 | Tag of the oldest load, 0 if empty |
| st_head_seq | output | 16 | Tag of the oldest store, 0 if empty |

## Verification
A head, writeback or tail pointer that is off by one shows up on wr_seq or wr_data at the next write. It also shows up on a head tag output as soon as the ring drains to that slot. A count register that drifts breaks the full flags and free_slots immediately, and the error remains visible until reset. A wrong committed or completed flag either produces a write out of order or no write at all. In the first case the scoreboard detects it at the write itself. In the second case a stuck st_wb value shows it within a few idle cycles.

// File: rtl/lsq_pkg.sv
package lsq_pkg;
  localparam int SEQ_W  = 16;
  localparam int DATA_W = 32;
  localparam int SIZE_W = 2;

  typedef logic [SEQ_W-1:0]  seq_t;
  typedef logic [DATA_W-1:0] word_t;
  typedef logic [SIZE_W-1:0] size_t;

  // one store slot: tag, payload and its progress flags
  typedef struct packed {
    seq_t  seq;
    size_t size;
    word_t data;
    logic  committed;
    logic  completed;
  } st_slot_t;
endpackage

// File: rtl/lsq_load_ring.sv
module lsq_load_ring
  import lsq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int CW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ins_req,
  input  seq_t          ins_seq,
  input  logic          cmt_req,
  input  seq_t          cmt_seq,
  input  logic          kill_req,
  input  seq_t          kill_seq,
  output logic [CW-1:0] count,
  output seq_t          head_seq,
  output logic          full
);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DEPTH-1:0] vld_q, vld_d, cmt_hit, kill_hit;
  seq_t             seq_q [DEPTH];
  logic [IW-1:0]    head_q, head_d, tail_q, tail_d;
  logic [CW-1:0]    cnt_q, cnt_d, n_cmt, n_kill;
  logic             ins_ok;

  function automatic logic [IW-1:0] fwd(input logic [IW-1:0] p, input logic [CW-1:0] n);
    int s;
    s = int'(p) + int'(n);
    if (s >= DEPTH) s = s - DEPTH;
    return IW'(s);
  endfunction

  function automatic logic [IW-1:0] back(input logic [IW-1:0] p, input logic [CW-1:0] n);
    int s;
    s = int'(p) - int'(n);
    if (s < 0) s = s + DEPTH;
    return IW'(s);
  endfunction

  assign full   = (cnt_q >= CW'(DEPTH - 1));
  assign ins_ok = ins_req & ~full;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      cmt_hit[i]  = cmt_req  & vld_q[i] & (seq_q[i] <= cmt_seq);
      kill_hit[i] = kill_req & vld_q[i] & (seq_q[i] >  kill_seq);
    end
    n_cmt  = CW'($countones(cmt_hit));
    n_kill = CW'($countones(kill_hit));
    vld_d  = vld_q & ~cmt_hit & ~kill_hit;
    if (ins_ok) vld_d[tail_q] = 1'b1;
    head_d = fwd(head_q, n_cmt);
    tail_d = ins_ok ? fwd(tail_q, CW'(1)) : back(tail_q, n_kill);
    cnt_d  = cnt_q + {{(CW-1){1'b0}}, ins_ok} - n_cmt - n_kill;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= '0;
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else begin
      vld_q  <= vld_d;
      head_q <= head_d;
      tail_q <= tail_d;
      cnt_q  <= cnt_d;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic wen;
    assign wen = ins_ok & (tail_q == IW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   seq_q[g] <= '0;
      else if (wen) seq_q[g] <= ins_seq;
    end
  end

  assign count    = cnt_q;
  assign head_seq = vld_q[head_q] ? seq_q[head_q] : '0;
endmodule

// File: rtl/lsq_store_ring.sv
module lsq_store_ring
  import lsq_pkg::*;
#(
  parameter int DEPTH = 6,
  parameter int CW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ins_req,
  input  seq_t          ins_seq,
  input  size_t         ins_size,
  input  word_t         ins_data,
  input  logic          cmt_req,
  input  seq_t          cmt_seq,
  input  logic          kill_req,
  input  seq_t          kill_seq,
  input  logic          blocked,
  output logic          wr_fire,
  output seq_t          wr_seq,
  output size_t         wr_size,
  output word_t         wr_data,
  output logic [CW-1:0] live_cnt,
  output logic [CW-1:0] wait_cnt,
  output logic [CW-1:0] occ_cnt,
  output seq_t          head_seq,
  output logic          full
);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  st_slot_t         ent_q [DEPTH];
  st_slot_t         ent_d [DEPTH];
  logic [DEPTH-1:0] vld_q, vld_d, cmt_hit, kill_hit;
  logic [IW-1:0]    head_q, head_d, wbp_q, wbp_d, tail_q, tail_d;
  logic [CW-1:0]    occ_q, occ_d, live_q, live_d, wait_q, wait_d, n_cmt, n_kill;
  logic             ins_ok, fire, hfree;

  function automatic logic [IW-1:0] fwd(input logic [IW-1:0] p, input logic [CW-1:0] n);
    int s;
    s = int'(p) + int'(n);
    if (s >= DEPTH) s = s - DEPTH;
    return IW'(s);
  endfunction

  function automatic logic [IW-1:0] back(input logic [IW-1:0] p, input logic [CW-1:0] n);
    int s;
    s = int'(p) - int'(n);
    if (s < 0) s = s + DEPTH;
    return IW'(s);
  endfunction

  assign full   = (occ_q >= CW'(DEPTH - 1));
  assign ins_ok = ins_req & ~full;
  assign fire   = vld_q[wbp_q] & ent_q[wbp_q].committed & ~ent_q[wbp_q].completed & ~blocked;
  assign hfree  = vld_q[head_q] & ent_q[head_q].completed;

  always_comb begin
    ent_d = ent_q;
    for (int i = 0; i < DEPTH; i++) begin
      cmt_hit[i]  = cmt_req  & vld_q[i] & ~ent_q[i].committed & (ent_q[i].seq <= cmt_seq);
      kill_hit[i] = kill_req & vld_q[i] & ~ent_q[i].committed & (ent_q[i].seq >  kill_seq);
      if (cmt_hit[i]) ent_d[i].committed = 1'b1;
      if (fire && (wbp_q == IW'(i))) ent_d[i].completed = 1'b1;
    end
    if (ins_ok) begin
      ent_d[tail_q].seq       = ins_seq;
      ent_d[tail_q].size      = ins_size;
      ent_d[tail_q].data      = ins_data;
      ent_d[tail_q].committed = 1'b0;
      ent_d[tail_q].completed = 1'b0;
    end
    n_cmt  = CW'($countones(cmt_hit));
    n_kill = CW'($countones(kill_hit));
    vld_d  = vld_q & ~kill_hit;
    if (hfree)  vld_d[head_q] = 1'b0;
    if (ins_ok) vld_d[tail_q] = 1'b1;
    head_d = hfree ? fwd(head_q, CW'(1)) : head_q;
    wbp_d  = fire  ? fwd(wbp_q,  CW'(1)) : wbp_q;
    tail_d = ins_ok ? fwd(tail_q, CW'(1)) : back(tail_q, n_kill);
    occ_d  = occ_q  + {{(CW-1){1'b0}}, ins_ok} - n_kill - {{(CW-1){1'b0}}, hfree};
    live_d = live_q + {{(CW-1){1'b0}}, ins_ok} - n_kill - n_cmt;
    wait_d = wait_q + n_cmt - {{(CW-1){1'b0}}, fire};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= '0;
      head_q <= '0;
      wbp_q  <= '0;
      tail_q <= '0;
      occ_q  <= '0;
      live_q <= '0;
      wait_q <= '0;
    end else begin
      vld_q  <= vld_d;
      head_q <= head_d;
      wbp_q  <= wbp_d;
      tail_q <= tail_d;
      occ_q  <= occ_d;
      live_q <= live_d;
      wait_q <= wait_d;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ent_q[g] <= '0;
      else        ent_q[g] <= ent_d[g];
    end
  end

  assign wr_fire  = fire;
  assign wr_seq   = ent_q[wbp_q].seq;
  assign wr_size  = ent_q[wbp_q].size;
  assign wr_data  = ent_q[wbp_q].data;
  assign live_cnt = live_q;
  assign wait_cnt = wait_q;
  assign occ_cnt  = occ_q;
  assign head_seq = vld_q[head_q] ? ent_q[head_q].seq : '0;
endmodule

// File: rtl/lsq_unit.sv
module lsq_unit
  import lsq_pkg::*;
#(
  parameter int LQ_DEPTH = 8,
  parameter int SQ_DEPTH = 6,
  localparam int MAXD    = (LQ_DEPTH > SQ_DEPTH) ? LQ_DEPTH : SQ_DEPTH,
  localparam int CW      = $clog2(MAXD + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_ins_valid,
  input  logic [15:0]   ld_ins_seq,
  input  logic          st_ins_valid,
  input  logic [15:0]   st_ins_seq,
  input  logic [1:0]    st_ins_size,
  input  logic [31:0]   st_ins_data,
  input  logic          cmt_valid,
  input  logic [15:0]   cmt_seq,
  input  logic          squash_valid,
  input  logic [15:0]   squash_seq,
  input  logic          dc_blocked,
  output logic          wr_valid,
  output logic [15:0]   wr_seq,
  output logic [1:0]    wr_size,
  output logic [31:0]   wr_data,
  output logic [CW-1:0] ld_count,
  output logic [CW-1:0] st_live,
  output logic [CW-1:0] st_wb,
  output logic [CW-1:0] free_slots,
  output logic          lq_full,
  output logic          sq_full,
  output logic          lsq_full,
  output logic [15:0]   ld_head_seq,
  output logic [15:0]   st_head_seq
);
  logic [1:0]    rs_q;
  logic          rst_int_n;
  logic          ld_ins_en, st_ins_en, cmt_en;
  logic [CW-1:0] st_occ, lq_free, sq_free;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_int_n = rs_q[1];

  // squash wins over dispatch and commit in the same cycle
  assign ld_ins_en = ld_ins_valid & ~squash_valid;
  assign st_ins_en = st_ins_valid & ~squash_valid;
  assign cmt_en    = cmt_valid    & ~squash_valid;

  lsq_load_ring #(.DEPTH(LQ_DEPTH), .CW(CW)) u_lring (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .ins_req  (ld_ins_en),
    .ins_seq  (ld_ins_seq),
    .cmt_req  (cmt_en),
    .cmt_seq  (cmt_seq),
    .kill_req (squash_valid),
    .kill_seq (squash_seq),
    .count    (ld_count),
    .head_seq (ld_head_seq),
    .full     (lq_full)
  );

  lsq_store_ring #(.DEPTH(SQ_DEPTH), .CW(CW)) u_sring (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .ins_req  (st_ins_en),
    .ins_seq  (st_ins_seq),
    .ins_size (st_ins_size),
    .ins_data (st_ins_data),
    .cmt_req  (cmt_en),
    .cmt_seq  (cmt_seq),
    .kill_req (squash_valid),
    .kill_seq (squash_seq),
    .blocked  (dc_blocked),
    .wr_fire  (wr_valid),
    .wr_seq   (wr_seq),
    .wr_size  (wr_size),
    .wr_data  (wr_data),
    .live_cnt (st_live),
    .wait_cnt (st_wb),
    .occ_cnt  (st_occ),
    .head_seq (st_head_seq),
    .full     (sq_full)
  );

  assign lsq_full   = lq_full | sq_full;
  assign lq_free    = CW'(LQ_DEPTH - 1) - ld_count;
  assign sq_free    = CW'(SQ_DEPTH - 1) - st_occ;
  assign free_slots = (lq_free < sq_free) ? lq_free : sq_free;
endmodule

// File: rtl/lsq_unit_chk.sv
module lsq_unit_chk #(
  parameter int LQ_DEPTH = 8,
  parameter int SQ_DEPTH = 6,
  parameter int CW       = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ld_ins_valid,
  input logic          cmt_valid,
  input logic          squash_valid,
  input logic          dc_blocked,
  input logic          wr_valid,
  input logic [CW-1:0] ld_count,
  input logic [CW-1:0] st_live,
  input logic [CW-1:0] st_wb,
  input logic          lq_full,
  input logic [15:0]   ld_head_seq
);
  // R4
  lq_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(ld_count) <= LQ_DEPTH - 1);

  // R4
  sq_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(st_live) + int'(st_wb) <= SQ_DEPTH - 1);

  // R7
  blocked_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dc_blocked |-> !wr_valid);

  // R6
  write_drains_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !cmt_valid) |=> (int'(st_wb) + 1 == int'($past(st_wb))));

  // R5
  full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lq_full && ld_ins_valid && !cmt_valid && !squash_valid) |=> (ld_count == $past(ld_count)));

  // R9
  squash_shrinks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    squash_valid |=> (ld_count <= $past(ld_count)));

  // R11
  empty_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_count == '0) |-> (ld_head_seq == 16'd0));
endmodule

bind lsq_unit lsq_unit_chk #(.LQ_DEPTH(LQ_DEPTH), .SQ_DEPTH(SQ_DEPTH), .CW(CW)) u_chk (.*);

// File: tb/lsq_unit_test.sv
module lsq_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld_ins_valid = 1'b0, st_ins_valid = 1'b0, cmt_valid = 1'b0;
  logic        squash_valid = 1'b0, dc_blocked = 1'b0;
  logic [15:0] ld_ins_seq = '0, st_ins_seq = '0, cmt_seq = '0, squash_seq = '0;
  logic [1:0]  st_ins_size = '0;
  logic [31:0] st_ins_data = '0;
  logic        wr_valid, lq_full, sq_full, lsq_full;
  logic [15:0] wr_seq, ld_head_seq, st_head_seq;
  logic [1:0]  wr_size;
  logic [31:0] wr_data;
  logic [3:0]  ld_count, st_live, st_wb, free_slots;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [49:0] exp_q [$];

  always #4 clk = ~clk;

  lsq_unit uut (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #2;
    ld_ins_valid = 0; st_ins_valid = 0; cmt_valid = 0; squash_valid = 0;
  endtask

  task automatic ins_ld(input logic [15:0] s);
    ld_ins_valid = 1; ld_ins_seq = s; tick();
  endtask

  task automatic ins_st(input logic [15:0] s, input logic [31:0] d, input logic [1:0] z);
    st_ins_valid = 1; st_ins_seq = s; st_ins_data = d; st_ins_size = z; tick();
  endtask

  task automatic commit(input logic [15:0] s);
    cmt_valid = 1; cmt_seq = s; tick();
  endtask

  task automatic expect_wr(input logic [15:0] s, input logic [31:0] d, input logic [1:0] z);
    exp_q.push_back({s, d, z});
  endtask

  // monitor: pop and compare each write the cache port emits
  always @(negedge clk) begin
    if (rst_n && wr_valid) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_bad++;
        $display("FAIL R6 unexpected write actual=%0h expected=none", wr_seq);
      end else begin
        logic [49:0] e;
        e = exp_q.pop_front();
        check("R6 wr_seq",  {16'd0, wr_seq}, {16'd0, e[49:34]});
        check("R6 wr_data", wr_data, e[33:2]);
        check("R6 wr_size", {30'd0, wr_size}, {30'd0, e[1:0]});
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk); #2;
    rst_n = 1;
    repeat (4) tick();
    // R1 reset state
    check("R1 ld_count", ld_count, 0);
    check("R1 st_live", st_live, 0);
    check("R1 st_wb", st_wb, 0);
    check("R1 free", free_slots, 5);
    check("R1 full", {lq_full, sq_full, lsq_full}, 0);
    check("R1 heads", {ld_head_seq, st_head_seq}, 0);
    check("R1 wr_valid", wr_valid, 0);

    // R2 inserts, loads and stores in the same cycle
    ld_ins_valid = 1; ld_ins_seq = 10; st_ins_valid = 1; st_ins_seq = 20;
    st_ins_data = 32'hA0; st_ins_size = 2; tick();
    ld_ins_valid = 1; ld_ins_seq = 11; st_ins_valid = 1; st_ins_seq = 21;
    st_ins_data = 32'hA1; st_ins_size = 1; tick();
    ins_ld(12);
    check("R2 ld_count", ld_count, 3);
    check("R2 st_live", st_live, 2);
    check("R4 free min", free_slots, 3);
    check("R2 ld_head", ld_head_seq, 10);
    check("R2 st_head", st_head_seq, 20);

    // R3 commit, R7 blocked cache
    dc_blocked = 1;
    commit(20);
    check("R3 loads freed", ld_count, 0);
    check("R11 ld_head empty", ld_head_seq, 0);
    check("R3 st_live", st_live, 1);
    check("R3 st_wb", st_wb, 1);
    check("R7 no write blocked", wr_valid, 0);
    tick();
    check("R7 st_wb held", st_wb, 1);

    // R6 write, R8 free one cycle later
    expect_wr(20, 32'hA0, 2);
    dc_blocked = 0;
    tick();
    check("R6 st_wb drop", st_wb, 0);
    check("R8 head not yet freed", st_head_seq, 20);
    tick();
    check("R8 head advanced", st_head_seq, 21);
    check("R4 free after free", free_slots, 4);

    // R4/R5 fill the store ring (wraps the tail past 6 slots)
    ins_st(22, 32'hB2, 0); ins_st(23, 32'hB3, 1); ins_st(24, 32'hB4, 2); ins_st(25, 32'hB5, 3);
    check("R4 sq_full", sq_full, 1);
    check("R4 lsq_full", lsq_full, 1);
    check("R4 lq_full", lq_full, 0);
    check("R4 free zero", free_slots, 0);
    ins_st(26, 32'hB6, 0);
    check("R5 full drop", st_live, 5);

    // R9 squash, R10 same-cycle commit and inserts ignored
    squash_valid = 1; squash_seq = 23;
    ld_ins_valid = 1; ld_ins_seq = 30; st_ins_valid = 1; st_ins_seq = 31;
    cmt_valid = 1; cmt_seq = 22;
    tick();
    check("R9 st_live", st_live, 3);
    check("R10 commit ignored", st_wb, 0);
    check("R10 load ignored", ld_count, 0);
    check("R9 sq_full", sq_full, 0);
    check("R9 free", free_slots, 2);

    // R12 reuse the slots past the wrap point, R6 order
    ins_st(40, 32'hC0, 2); ins_st(41, 32'hC1, 1);
    check("R12 sq_full again", sq_full, 1);
    expect_wr(21, 32'hA1, 1); expect_wr(22, 32'hB2, 0);
    expect_wr(23, 32'hB3, 1); expect_wr(40, 32'hC0, 2);
    commit(40);
    check("R3 four committed", st_wb, 4);
    repeat (6) tick();
    check("R6 drained", st_wb, 0);
    check("R8 head 41", st_head_seq, 41);
    check("R12 st_live", st_live, 1);
    check("R12 free", free_slots, 4);

    ins_st(42, 32'hD2, 3); ins_st(43, 32'hD3, 0); ins_st(44, 32'hD4, 1);
    dc_blocked = 1;
    commit(43);
    check("R3 wb three", st_wb, 3);
    repeat (2) tick();
    check("R7 held", st_wb, 3);
    expect_wr(41, 32'hC1, 1); expect_wr(42, 32'hD2, 3); expect_wr(43, 32'hD3, 0);
    dc_blocked = 0;
    repeat (6) tick();
    check("R6 wrap drained", st_wb, 0);
    check("R12 head 44", st_head_seq, 44);
    check("R6 scoreboard empty", exp_q.size(), 0);

    // R4/R5 load ring full, R12 load wrap, R9 squash of loads
    for (int i = 0; i < 7; i++) ins_ld(16'(50 + i));
    check("R4 lq_full", lq_full, 1);
    check("R4 lsq_full loads", lsq_full, 1);
    check("R4 free loads", free_slots, 0);
    ins_ld(57);
    check("R5 load drop", ld_count, 7);
    expect_wr(44, 32'hD4, 1);
    commit(52);
    check("R3 ld partial", ld_count, 4);
    check("R2 ld_head 53", ld_head_seq, 53);
    ins_ld(60); ins_ld(61); ins_ld(62);
    check("R12 ld_count", ld_count, 7);
    squash_valid = 1; squash_seq = 55; tick();
    check("R9 ld squash", ld_count, 3);
    check("R9 ld head kept", ld_head_seq, 53);
    commit(60);
    check("R3 all loads", ld_count, 0);
    check("R11 ld empty", ld_head_seq, 0);
    repeat (4) tick();
    check("R11 st empty", st_head_seq, 0);
    check("R1 free back", free_slots, 5);
    check("R6 final scoreboard", exp_q.size(), 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule